// File: doc/BRIEF.md
# Parallel Printer Port Host Controller

This block is the host side of an 8-bit parallel printer port. Software reaches it through four byte-wide registers: one for the data byte, one read-only register that mirrors the printer's status lines, one for control and one for the handshake engine. The block drives the eight data lines, an active-low strobe and three active-low control outputs (auto line feed, printer init, select-in). It samples five printer status inputs and the incoming data byte through two-flop synchronisers.

A write to the data register while the engine is idle and the port is set for output starts a hardware transfer. The engine waits until the printer is not busy, then holds the byte on the lines for a setup window. It pulses strobe low for a fixed width, keeps the byte for a hold window, and then waits for the printer's acknowledge. Every window is a whole number of clock cycles, rounded up from its minimum time at the configured clock frequency. An acknowledge sets a done flag. If no acknowledge arrives within the timeout, the transfer ends with a timeout flag instead. With interrupts enabled, each falling edge of acknowledge raises a one-cycle interrupt pulse.

The register port is a plain single-cycle write strobe with a combinational read, and it applies no back-pressure. A data write that arrives while a transfer is in flight is dropped. Software learns when the port can take the next byte by polling the engine register or by waiting for the interrupt.

Top module: `lpt_host_port`

## Requirements
- R1: After reset, the control register reads 0x04 and the engine register reads 0x00. `strobe_n`, `autofd_n`, `init_n` and `selin_n` are all 1, `irq` is 0 and `pd_oe` is 1.
- R2: The status register (address 1) reads {not-busy, ack-active, paper-out, online, no-error, 3'b000} from bit 7 down to bit 0. The values come from the printer inputs after two-stage synchronisation: not-busy = ~`prn_busy`, ack-active = ~`prn_ack_n`, no-error = `prn_err_n`.
- R3: Control register (address 2) bit 0 drives `strobe_n` low, bit 1 drives `autofd_n` low and bit 3 drives `selin_n` low. Bit 2 = 0 drives `init_n` low. Bit 4 enables interrupts. Bit 5 = 1 selects input direction (`pd_oe` = 0, and a data register read returns the synchronised `pd_in`). The register reads back as written.
- R4: A write to the data register (address 0) while the engine is idle and bit 5 is 0 starts a transfer. `pd_out` carries the byte for at least SETUP_CYC cycles (25 at 50 MHz) before `strobe_n` falls.
- R5: An engine strobe pulse keeps `strobe_n` low for exactly PULSE_CYC cycles (25 at 50 MHz).
- R6: `pd_out` stays unchanged for at least HOLD_CYC cycles (25 at 50 MHz) after `strobe_n` rises.
- R7: While the synchronised busy input is 1, the engine does not lower strobe. The transfer stays active and continues once busy clears.
- R8: Engine register (address 3) bit 2 is 1 while a transfer is active. Bit 0 (done) is set when a falling edge of acknowledge is seen after strobe. Starting a new transfer clears bits 0 and 1.
- R9: If no acknowledge arrives within TIMEOUT_CYC cycles (1000 at 50 MHz) after the hold window, the transfer ends with bit 1 (timeout) set and bit 0 clear. Done and timeout are never both set.
- R10: A data register write during an active transfer has no effect: the byte on `pd_out` and in the data register is unchanged, and no extra strobe follows.
- R11: With control bit 4 set, each falling edge of `prn_ack_n` produces exactly one single-cycle `irq` pulse. With bit 4 clear, `irq` stays 0.
- R12: A data register write while control bit 5 is 1 starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 engine |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pd_out | output | 8 | Data lines toward the printer |
| pd_in | input | 8 | Data lines from the printer (input direction) |
| pd_oe | output | 1 | 1 = drive data lines (output direction) |
| strobe_n | output | 1 | Active-low data strobe |
| autofd_n | output | 1 | Active-low auto line feed |
| init_n | output | 1 | Active-low printer initialise |
| selin_n | output | 1 | Active-low select-in |
| prn_busy | input | 1 | Printer busy, active high |
| prn_ack_n | input | 1 | Printer acknowledge, active low |
| prn_paper_out | input | 1 | Paper out, active high |
| prn_online | input | 1 | Printer selected / online |
| prn_err_n | input | 1 | Printer fault, active low |
| irq | output | 1 | One-cycle interrupt pulse on acknowledge |

## Verification
A wrong engine state shows at the pins within one window. A corrupted counter changes the strobe width or the data setup time at the next falling strobe. A state that leaves the handshake wrongly shows as an extra strobe, which the scoreboard catches at once as an unexpected byte, or as a missing strobe, which shows as leftover expected bytes. A broken acknowledge path shows either as a timeout flag about 1000 cycles after the hold window where done was expected, or as an interrupt count that is off by one. A mapping error in the status or control register shows on the very next read, or on the pin it drives.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_PULSE,
    ENG_HOLD,
    ENG_WAIT
  } eng_state_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_ENG  = 2'd3;

  localparam int CTL_STROBE = 0;
  localparam int CTL_AUTOFD = 1;
  localparam int CTL_INIT   = 2;
  localparam int CTL_SELECT = 3;
  localparam int CTL_IRQEN  = 4;
  localparam int CTL_DIR    = 5;

  localparam logic [7:0] CTRL_RST = 8'h04;

  // Ceiling of clk_khz * ns / 1e6, never less than one cycle.
  function automatic int ns_to_cycles(input int clk_khz, input int ns);
    int c;
    c = (clk_khz * ns + 999_999) / 1_000_000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int us_to_cycles(input int clk_khz, input int us);
    int c;
    c = (clk_khz * us + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lpt_engine.sv
module lpt_engine
  import lpt_pkg::*;
#(
  parameter int SETUP_CYC   = 25,
  parameter int PULSE_CYC   = 25,
  parameter int HOLD_CYC    = 25,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy_s,
  input  logic ack_fall,
  output logic strobe,
  output logic active,
  output logic done,
  output logic timeout
);
  localparam int MAXW = (TIMEOUT_CYC > SETUP_CYC) ? TIMEOUT_CYC : SETUP_CYC;
  localparam int MAXP = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
  localparam int MAXC = (MAXW > MAXP) ? MAXW : MAXP;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST   = CW'(TIMEOUT_CYC - 1);

  eng_state_t    state;
  logic [CW-1:0] cnt;
  logic          ack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: if (start) begin
          state    <= ENG_SETUP;
          cnt      <= '0;
          done     <= 1'b0;
          timeout  <= 1'b0;
          ack_seen <= 1'b0;
        end
        ENG_SETUP: begin
          if (busy_s)                 cnt <= '0;
          else if (cnt == SETUP_LAST) begin state <= ENG_PULSE; cnt <= '0; end
          else                        cnt <= cnt + 1'b1;
        end
        ENG_PULSE: begin
          if (ack_fall) ack_seen <= 1'b1;
          if (cnt == PULSE_LAST) begin state <= ENG_HOLD; cnt <= '0; end
          else                   cnt <= cnt + 1'b1;
        end
        ENG_HOLD: begin
          if (ack_fall) ack_seen <= 1'b1;
          if (cnt == HOLD_LAST) begin state <= ENG_WAIT; cnt <= '0; end
          else                  cnt <= cnt + 1'b1;
        end
        ENG_WAIT: begin
          if (ack_seen || ack_fall) begin
            state <= ENG_IDLE;
            done  <= 1'b1;
          end else if (cnt == TMO_LAST) begin
            state   <= ENG_IDLE;
            timeout <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign strobe = (state == ENG_PULSE);
  assign active = (state != ENG_IDLE);

  // Checker: length of the current strobe-high run
  logic [CW-1:0] pulse_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pulse_run <= '0;
    else if (strobe) pulse_run <= pulse_run + 1'b1;
    else             pulse_run <= '0;

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> pulse_run == CW'(PULSE_CYC));

  assert_no_strobe_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> !$past(busy_s));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  assert_flags_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !done && !timeout);
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pd_in_s,
  input  logic [4:0] stat_bits,
  input  logic       eng_active,
  input  logic       eng_done,
  input  logic       eng_timeout,
  output logic [7:0] ctrl_q,
  output logic [7:0] data_q,
  output logic       start
);
  logic data_wr, ctrl_wr;

  assign data_wr = wr_en && (addr == ADDR_DATA) && !eng_active;
  assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
  assign start   = data_wr && !ctrl_q[CTL_DIR];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      data_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= {2'b00, wdata[5:0]};
      if (data_wr) data_q <= wdata;
    end

  always_comb begin
    case (addr)
      ADDR_DATA: rdata = ctrl_q[CTL_DIR] ? pd_in_s : data_q;
      ADDR_STAT: rdata = {stat_bits, 3'b000};
      ADDR_CTRL: rdata = ctrl_q;
      default:   rdata = {5'b0, eng_active, eng_timeout, eng_done};
    endcase
  end

  assert_data_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active && $past(eng_active) |-> $stable(data_q));

  assert_no_start_input_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTL_DIR] && $past(ctrl_q[CTL_DIR]) && !$past(eng_active) |-> !eng_active);
endmodule

// File: rtl/lpt_host_port.sv
module lpt_host_port
  import lpt_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SETUP_NS   = 500,
  parameter int PULSE_NS   = 500,
  parameter int HOLD_NS    = 500,
  parameter int TIMEOUT_US = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [7:0] pd_out,
  input  logic [7:0] pd_in,
  output logic       pd_oe,
  output logic       strobe_n,
  output logic       autofd_n,
  output logic       init_n,
  output logic       selin_n,
  input  logic       prn_busy,
  input  logic       prn_ack_n,
  input  logic       prn_paper_out,
  input  logic       prn_online,
  input  logic       prn_err_n,
  output logic       irq
);
  localparam int CLK_KHZ     = (CLK_HZ + 999) / 1000;
  localparam int SETUP_CYC   = ns_to_cycles(CLK_KHZ, SETUP_NS);
  localparam int PULSE_CYC   = ns_to_cycles(CLK_KHZ, PULSE_NS);
  localparam int HOLD_CYC    = ns_to_cycles(CLK_KHZ, HOLD_NS);
  localparam int TIMEOUT_CYC = us_to_cycles(CLK_KHZ, TIMEOUT_US);
  localparam int SW          = 13;
  localparam logic [SW-1:0] SYNC_RST = {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic [SW-1:0] sync_q;
  logic [7:0]    pd_in_s;
  logic          busy_s, ack_n_s, paper_s, online_s, err_n_s;

  lpt_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pd_in, prn_busy, prn_ack_n, prn_paper_out, prn_online, prn_err_n}),
    .q(sync_q)
  );
  assign {pd_in_s, busy_s, ack_n_s, paper_s, online_s, err_n_s} = sync_q;

  logic ack_prev, ack_fall;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_prev <= 1'b1;
    else        ack_prev <= ack_n_s;
  assign ack_fall = ack_prev && !ack_n_s;

  logic [7:0] ctrl_q, data_q;
  logic       start, eng_strobe, eng_active, eng_done, eng_timeout;

  lpt_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr(reg_addr), .wr_en(reg_wr), .wdata(reg_wdata), .rdata(reg_rdata),
    .pd_in_s(pd_in_s),
    .stat_bits({~busy_s, ~ack_n_s, paper_s, online_s, err_n_s}),
    .eng_active(eng_active), .eng_done(eng_done), .eng_timeout(eng_timeout),
    .ctrl_q(ctrl_q), .data_q(data_q), .start(start)
  );

  lpt_engine #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(start), .busy_s(busy_s), .ack_fall(ack_fall),
    .strobe(eng_strobe), .active(eng_active),
    .done(eng_done), .timeout(eng_timeout)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= ctrl_q[CTL_IRQEN] && ack_fall;

  assign pd_out   = data_q;
  assign pd_oe    = !ctrl_q[CTL_DIR];
  assign strobe_n = !(ctrl_q[CTL_STROBE] || eng_strobe);
  assign autofd_n = !ctrl_q[CTL_AUTOFD];
  assign init_n   = ctrl_q[CTL_INIT];
  assign selin_n  = !ctrl_q[CTL_SELECT];

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_q[CTL_IRQEN]));

  assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_strobe && $past(eng_strobe) |-> $stable(pd_out));
endmodule

// File: tb/lpt_host_port_bench.sv
module lpt_host_port_bench;
  localparam int SETUP = 25;
  localparam int PULSE = 25;
  localparam int HOLD  = 25;
  localparam int TMO   = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, pd_out;
  logic [7:0] pd_in = 8'h00;
  logic       pd_oe, strobe_n, autofd_n, init_n, selin_n, irq;
  logic       prn_busy = 1'b0, prn_ack_n = 1'b1, prn_paper_out = 1'b0;
  logic       prn_online = 1'b1, prn_err_n = 1'b1;

  always #10 clk = ~clk;

  lpt_host_port u_lpt_host_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_out(pd_out),
    .pd_in(pd_in), .pd_oe(pd_oe), .strobe_n(strobe_n), .autofd_n(autofd_n),
    .init_n(init_n), .selin_n(selin_n), .prn_busy(prn_busy),
    .prn_ack_n(prn_ack_n), .prn_paper_out(prn_paper_out),
    .prn_online(prn_online), .prn_err_n(prn_err_n), .irq(irq)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  bit model_on = 0, mon_ignore = 0;
  int ack_dly = 10;
  int strobe_falls = 0, irq_count = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Driver: pushes the expected byte and writes it
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    reg_write(2'd0, b);
  endtask

  task automatic wait_idle();
    logic [7:0] r;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      reg_read(2'd3, r);
      if (!r[2]) return;
    end
    chk(0, "R8", "engine never returned idle", 1, 0);
  endtask

  // Printer model
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!strobe_n && prev && model_on && !mon_ignore) begin
        prn_busy = 1'b1;
        repeat (ack_dly) @(negedge clk);
        prn_ack_n = 1'b0;
        repeat (3) @(negedge clk);
        prn_ack_n = 1'b1;
        prn_busy = 1'b0;
      end
      prev = strobe_n;
    end
  end

  // Monitor / scoreboard
  initial begin
    logic prev_s = 1'b1, prev_irq = 1'b0;
    logic [7:0] prev_d = 8'h00, cap = 8'h00;
    int stable_cnt = 0, low_cnt = 0, hold_left = 0;
    bit hold_ok = 1;
    forever begin
      @(negedge clk);
      if (pd_out == prev_d) stable_cnt++; else stable_cnt = 0;
      if (irq) irq_count++;
      if (irq && prev_irq) chk(0, "R11", "irq longer than one cycle", 2, 1);
      if (!mon_ignore) begin
        if (!strobe_n && prev_s) begin
          strobe_falls++;
          low_cnt = 1;
          cap = pd_out;
          chk(stable_cnt >= SETUP, "R4", "setup cycles", stable_cnt, SETUP);
          if (exp_q.size() == 0) chk(0, "R10", "unexpected strobe, byte", pd_out, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(pd_out == e, "R4", "strobed byte", pd_out, e);
          end
        end else if (!strobe_n) begin
          low_cnt++;
        end else if (strobe_n && !prev_s) begin
          chk(low_cnt == PULSE, "R5", "strobe low cycles", low_cnt, PULSE);
          hold_left = HOLD; hold_ok = 1;
        end else if (hold_left > 0) begin
          if (pd_out != cap) hold_ok = 0;
          hold_left--;
          if (hold_left == 0) chk(hold_ok, "R6", "data held after strobe", pd_out, cap);
        end
      end
      prev_s = strobe_n; prev_d = pd_out; prev_irq = irq;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int f0, i0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd2, r); chk(r == 8'h04, "R1", "ctrl reset", r, 8'h04);
    reg_read(2'd3, r); chk(r == 8'h00, "R1", "engine reset", r, 8'h00);
    chk({strobe_n, autofd_n, init_n, selin_n, irq, pd_oe} == 6'b111101, "R1", "pins",
        {strobe_n, autofd_n, init_n, selin_n, irq, pd_oe}, 6'b111101);

    // R2 status mapping, two patterns
    prn_busy = 1; prn_ack_n = 0; prn_paper_out = 1; prn_online = 0; prn_err_n = 1;
    repeat (4) @(negedge clk);
    reg_read(2'd1, r); chk(r == 8'h68, "R2", "status pattern A", r, 8'h68);
    prn_busy = 0; prn_ack_n = 1; prn_paper_out = 0; prn_online = 1; prn_err_n = 0;
    repeat (4) @(negedge clk);
    reg_read(2'd1, r); chk(r == 8'h90, "R2", "status pattern B", r, 8'h90);
    prn_err_n = 1;
    repeat (4) @(negedge clk);

    // R3 control bits
    reg_write(2'd2, 8'h0A);
    reg_read(2'd2, r); chk(r == 8'h0A, "R3", "ctrl readback", r, 8'h0A);
    chk({strobe_n, autofd_n, init_n, selin_n} == 4'b1000, "R3", "ctrl pins 0x0A",
        {strobe_n, autofd_n, init_n, selin_n}, 4'b1000);
    mon_ignore = 1;
    reg_write(2'd2, 8'h05);
    chk({strobe_n, autofd_n, init_n, selin_n} == 4'b0111, "R3", "ctrl pins 0x05",
        {strobe_n, autofd_n, init_n, selin_n}, 4'b0111);
    reg_write(2'd2, 8'h04);
    @(negedge clk);
    mon_ignore = 0;
    @(negedge clk);

    // R4-R6, R8 normal transfers
    model_on = 1;
    send_byte(8'hA5);
    reg_read(2'd3, r); chk(r == 8'h04, "R8", "active, no done yet", r, 8'h04);
    wait_idle();
    reg_read(2'd3, r); chk(r == 8'h01, "R8", "done after ack", r, 8'h01);
    send_byte(8'h3C);
    reg_read(2'd3, r); chk(r[0] == 1'b0, "R8", "done cleared on start", r[0], 0);
    wait_idle();
    ack_dly = 150;
    send_byte(8'h81);
    wait_idle();
    reg_read(2'd3, r); chk(r == 8'h01, "R8", "done after late ack", r, 8'h01);
    ack_dly = 10;

    // R10 write during transfer ignored
    send_byte(8'h55);
    repeat (5) @(negedge clk);
    reg_write(2'd0, 8'hFF);
    wait_idle();
    repeat (3) @(negedge clk);
    reg_read(2'd0, r); chk(r == 8'h55, "R10", "data register kept", r, 8'h55);
    chk(pd_out == 8'h55, "R10", "pd_out kept", pd_out, 8'h55);

    // R11 interrupt enabled / disabled
    reg_write(2'd2, 8'h14);
    i0 = irq_count;
    send_byte(8'h12); wait_idle(); repeat (5) @(negedge clk);
    chk(irq_count - i0 == 1, "R11", "irq pulses enabled", irq_count - i0, 1);
    reg_write(2'd2, 8'h04);
    i0 = irq_count;
    send_byte(8'h34); wait_idle(); repeat (5) @(negedge clk);
    chk(irq_count - i0 == 0, "R11", "irq pulses disabled", irq_count - i0, 0);

    // R7 busy holds off strobe
    model_on = 0; prn_busy = 1;
    repeat (4) @(negedge clk);
    f0 = strobe_falls;
    send_byte(8'h42);
    repeat (100) @(negedge clk);
    chk(strobe_falls == f0, "R7", "no strobe while busy", strobe_falls - f0, 0);
    reg_read(2'd3, r); chk(r[2] == 1'b1, "R7", "still active while busy", r[2], 1);
    model_on = 1; prn_busy = 0;
    wait_idle();
    chk(strobe_falls == f0 + 1, "R7", "strobe after busy clears", strobe_falls - f0, 1);

    // R9 timeout
    model_on = 0;
    send_byte(8'h77);
    repeat (SETUP + PULSE + HOLD + TMO - 15) @(negedge clk);
    reg_read(2'd3, r); chk(r == 8'h04, "R9", "active before timeout", r, 8'h04);
    repeat (30) @(negedge clk);
    reg_read(2'd3, r); chk(r == 8'h02, "R9", "timeout flag", r, 8'h02);
    model_on = 1;
    send_byte(8'h66);
    reg_read(2'd3, r); chk(r == 8'h04, "R9", "timeout cleared on start", r, 8'h04);
    wait_idle();

    // R12 input direction
    reg_write(2'd2, 8'h24);
    chk(pd_oe == 1'b0, "R3", "pd_oe in input dir", pd_oe, 0);
    pd_in = 8'h5A;
    repeat (4) @(negedge clk);
    reg_read(2'd0, r); chk(r == 8'h5A, "R3", "read pd_in", r, 8'h5A);
    f0 = strobe_falls;
    reg_write(2'd0, 8'h11);
    repeat (100) @(negedge clk);
    chk(strobe_falls == f0, "R12", "no transfer in input dir", strobe_falls - f0, 0);
    reg_read(2'd3, r); chk(r[2] == 1'b0, "R12", "engine idle", r[2], 0);
    reg_write(2'd2, 8'h04);
    chk(pd_oe == 1'b1, "R3", "pd_oe back to output", pd_oe, 1);

    chk(exp_q.size() == 0, "R4", "bytes left in scoreboard", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule